// File: doc/BRIEF.md
# Encoded Clock Scaling Divider

This block derives three slower clocks from one oscillator clock. The main scaler takes a 3-bit select code. That code maps onto a non-monotonic set of ratios: {4, 6, 8, 10, 12, 2, 16, pass-through}. A second channel is a reference divider with a 2-bit code. Its ratios are 2, 3, 4 and pass-through, and divide-by-3 produces a one-high, two-low waveform. A third channel is a 2-bit post scaler covering 2, 4, 8 and 16. Every even ratio gives a 50% duty cycle. Each output is registered, so it changes only on a rising edge of the input clock.

A new select code does not take effect at once. Each channel holds its active ratio and replaces it only at the end of the period in progress, so no shortened pulse appears on the output. Each channel has its own enable input; driving it low forces that output to 0. A matching status output reports whether the channel is currently driving, and it stands in for a high-impedance state. Pass-through routes the input clock straight to the output. The pass-through setting is meant to be chosen while the synchronous reset is held, because the reset loads the select codes directly.

Top module: `enc_clk_scaler`

## Requirements
- R1: With rst_n high, scale_en high and scale_sel at 000, 001, 010, 011 or 100, scale_clk has a period of 4, 6, 8, 10 or 12 input cycles. Each period is high for half of those cycles and low for the other half.
- R2: With scale_sel at 101, scale_clk has a period of 2 input cycles, high 1 and low 1. With scale_sel at 110, the period is 16 input cycles, high 8 and low 8.
- R3: With scale_sel at 111 and scale_en high, scale_clk equals clk_in: it is high during the high phase of clk_in and low during its low phase.
- R4: With post_sel at 00, 01, 10 or 11, post_clk has a period of 2, 4, 8 or 16 input cycles, with a 50% duty cycle.
- R5: With ref_sel at 00 or 10, ref_clk has a period of 2 or 4 input cycles with a 50% duty cycle. With ref_sel at 01, the period is 3 input cycles: high for 1 and low for 2.
- R6: With ref_sel at 11 and ref_en high, ref_clk equals clk_in.
- R7: An enable input sampled low at a rising edge of clk_in has two effects from that edge on. The channel's output is held at 0, pass-through included, and its status output reads 0. An enable sampled high sets the status output to 1 and releases the output.
- R8: A select code that changes in the middle of a period has no effect on that period. The current period completes at the old ratio, and the next period uses the new one.
- R9: While rst_n is low, every channel with a ratio other than pass-through outputs 0. At the first rising edge with rst_n high, each such output goes high and begins its first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Oscillator clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; loads the select codes |
| scale_sel | input | 3 | Main scaler ratio code |
| ref_sel | input | 2 | Reference divider ratio code |
| post_sel | input | 2 | Post scaler ratio code |
| scale_en | input | 1 | Main scaler output enable, low forces 0 |
| ref_en | input | 1 | Reference divider output enable, low forces 0 |
| post_en | input | 1 | Post scaler output enable, low forces 0 |
| scale_clk | output | 1 | Main scaler output clock |
| ref_clk | output | 1 | Reference divider output clock |
| post_clk | output | 1 | Post scaler output clock |
| scale_drv | output | 1 | Main scaler output is being driven |
| ref_drv | output | 1 | Reference divider output is being driven |
| post_drv | output | 1 | Post scaler output is being driven |

## Verification
Divided outputs are registered, so each level change appears one rising edge after the counter reaches a boundary. After reset is released, the first high level appears at the first rising edge. An enable change takes hold at the next rising edge, and a new select code waits for the end of the current period, up to 16 cycles. The bench drives inputs and samples the divided outputs at falling edges, half a cycle clear of any update. It measures high and low run lengths only after it has seen a rising transition. The pass-through checks sample 2 ns after each edge of the input clock.

// File: rtl/enc_scaler_pkg.sv
package enc_scaler_pkg;

  localparam int SCL_MAX_RATIO = 16;
  localparam int SCL_RATIO_W   = $clog2(SCL_MAX_RATIO + 1);
  localparam int SCL_CNT_W     = $clog2(SCL_MAX_RATIO);
  localparam int SCL_NUM_CH    = 3;

  localparam int CH_SCALE = 0;
  localparam int CH_REF   = 1;
  localparam int CH_POST  = 2;

  typedef logic [SCL_RATIO_W-1:0] ratio_t;
  typedef logic [SCL_CNT_W-1:0]   cnt_t;

  // main scaler: non-monotonic code map, 111 is pass-through
  function automatic ratio_t scale_ratio(input logic [2:0] code);
    case (code)
      3'b000:  return ratio_t'(4);
      3'b001:  return ratio_t'(6);
      3'b010:  return ratio_t'(8);
      3'b011:  return ratio_t'(10);
      3'b100:  return ratio_t'(12);
      3'b101:  return ratio_t'(2);
      3'b110:  return ratio_t'(16);
      default: return ratio_t'(1);
    endcase
  endfunction

  // reference divider: 11 is pass-through
  function automatic ratio_t ref_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return ratio_t'(2);
      2'b01:   return ratio_t'(3);
      2'b10:   return ratio_t'(4);
      default: return ratio_t'(1);
    endcase
  endfunction

  // post scaler: powers of two
  function automatic ratio_t post_ratio(input logic [1:0] code);
    return ratio_t'(2) << code;
  endfunction

  // cycles spent high per period; odd ratio 3 gets one high cycle
  function automatic ratio_t high_len(input ratio_t r);
    if (r == ratio_t'(3)) return ratio_t'(1);
    return r >> 1;
  endfunction

endpackage

// File: rtl/scl_ratio_decoder.sv
module scl_ratio_decoder
  import enc_scaler_pkg::*;
(
  input  logic [2:0]                  scale_code,
  input  logic [1:0]                  ref_code,
  input  logic [1:0]                  post_code,
  output ratio_t [SCL_NUM_CH-1:0]     ratio_req
);

  always_comb begin
    ratio_req[CH_SCALE] = scale_ratio(scale_code);
    ratio_req[CH_REF]   = ref_ratio(ref_code);
    ratio_req[CH_POST]  = post_ratio(post_code);
  end

endmodule

// File: rtl/scl_ratio_divider.sv
module scl_ratio_divider
  import enc_scaler_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_req,
  output logic   q,
  output logic   wrap,
  output logic   bypass,
  output ratio_t ratio_act,
  output cnt_t   cnt
);

  ratio_t nxt_ratio;
  cnt_t   nxt_cnt;

  // last cycle of the current period
  assign wrap      = (ratio_t'(cnt) == (ratio_act - ratio_t'(1)));
  assign nxt_ratio = wrap ? ratio_req : ratio_act;
  assign nxt_cnt   = wrap ? '0 : cnt + cnt_t'(1);
  assign bypass    = (ratio_act == ratio_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_act <= ratio_req;
      cnt       <= cnt_t'(ratio_req - ratio_t'(1));
      q         <= 1'b0;
    end else begin
      ratio_act <= nxt_ratio;
      cnt       <= nxt_cnt;
      q         <= (ratio_t'(nxt_cnt) < high_len(nxt_ratio));
    end
  end

endmodule

// File: rtl/scl_out_gate.sv
module scl_out_gate (
  input  logic clk,
  input  logic en,
  input  logic q,
  input  logic bypass,
  output logic clk_o,
  output logic drv
);

  logic en_q;

  always_ff @(posedge clk) begin
    en_q <= en;
  end

  assign clk_o = en_q & (bypass ? clk : q);
  assign drv   = en_q;

endmodule

// File: rtl/enc_clk_scaler.sv
module enc_clk_scaler
  import enc_scaler_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [2:0] scale_sel,
  input  logic [1:0] ref_sel,
  input  logic [1:0] post_sel,
  input  logic       scale_en,
  input  logic       ref_en,
  input  logic       post_en,
  output logic       scale_clk,
  output logic       ref_clk,
  output logic       post_clk,
  output logic       scale_drv,
  output logic       ref_drv,
  output logic       post_drv
);

  ratio_t [SCL_NUM_CH-1:0] req_vec;
  ratio_t [SCL_NUM_CH-1:0] act_vec;
  cnt_t   [SCL_NUM_CH-1:0] cnt_vec;
  logic   [SCL_NUM_CH-1:0] en_vec;
  logic   [SCL_NUM_CH-1:0] q_vec;
  logic   [SCL_NUM_CH-1:0] wrap_vec;
  logic   [SCL_NUM_CH-1:0] byp_vec;
  logic   [SCL_NUM_CH-1:0] clk_vec;
  logic   [SCL_NUM_CH-1:0] drv_vec;

  assign en_vec[CH_SCALE] = scale_en;
  assign en_vec[CH_REF]   = ref_en;
  assign en_vec[CH_POST]  = post_en;

  scl_ratio_decoder u_dec (
    .scale_code (scale_sel),
    .ref_code   (ref_sel),
    .post_code  (post_sel),
    .ratio_req  (req_vec)
  );

  for (genvar g = 0; g < SCL_NUM_CH; g++) begin : g_ch
    scl_ratio_divider u_div (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .ratio_req (req_vec[g]),
      .q         (q_vec[g]),
      .wrap      (wrap_vec[g]),
      .bypass    (byp_vec[g]),
      .ratio_act (act_vec[g]),
      .cnt       (cnt_vec[g])
    );

    scl_out_gate u_gate (
      .clk    (clk_in),
      .en     (en_vec[g]),
      .q      (q_vec[g]),
      .bypass (byp_vec[g]),
      .clk_o  (clk_vec[g]),
      .drv    (drv_vec[g])
    );
  end

  assign scale_clk = clk_vec[CH_SCALE];
  assign ref_clk   = clk_vec[CH_REF];
  assign post_clk  = clk_vec[CH_POST];
  assign scale_drv = drv_vec[CH_SCALE];
  assign ref_drv   = drv_vec[CH_REF];
  assign post_drv  = drv_vec[CH_POST];

endmodule

// File: rtl/enc_clk_scaler_chk.sv
module enc_clk_scaler_chk
  import enc_scaler_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic   [SCL_NUM_CH-1:0] en,
  input logic   [SCL_NUM_CH-1:0] clk_o,
  input logic   [SCL_NUM_CH-1:0] drv,
  input logic   [SCL_NUM_CH-1:0] q,
  input logic   [SCL_NUM_CH-1:0] wrap,
  input ratio_t [SCL_NUM_CH-1:0] act,
  input cnt_t   [SCL_NUM_CH-1:0] cnt
);

  for (genvar g = 0; g < SCL_NUM_CH; g++) begin : g_chk
    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap[g] |=> $stable(act[g]));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_t'(cnt[g]) < act[g]);

    // R1
    edge_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q[g]) |-> (cnt[g] == '0 || ratio_t'(cnt[g]) == high_len(act[g])));

    // R7
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |=> (clk_o[g] == 1'b0 && drv[g] == 1'b0));

    // R7
    enabled_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] |=> drv[g]);
  end

endmodule

bind enc_clk_scaler enc_clk_scaler_chk u_chk (
  .clk   (clk_in),
  .rst_n (rst_n),
  .en    (en_vec),
  .clk_o (clk_vec),
  .drv   (drv_vec),
  .q     (q_vec),
  .wrap  (wrap_vec),
  .act   (act_vec),
  .cnt   (cnt_vec)
);

// File: tb/enc_clk_scaler_bench.sv
module enc_clk_scaler_bench;

  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] scale_sel = 3'b000;
  logic [1:0] ref_sel = 2'b00;
  logic [1:0] post_sel = 2'b00;
  logic       scale_en = 1'b1;
  logic       ref_en = 1'b1;
  logic       post_en = 1'b1;
  logic       scale_clk, ref_clk, post_clk;
  logic       scale_drv, ref_drv, post_drv;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_in = ~clk_in;

  enc_clk_scaler u_enc_clk_scaler (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int ch);
    case (ch)
      0:       return scale_clk;
      1:       return ref_clk;
      default: return post_clk;
    endcase
  endfunction

  function automatic int hi_of(input int r);
    return (r == 3) ? 1 : r / 2;
  endfunction

  task automatic do_reset(input logic [2:0] s, input logic [1:0] r, input logic [1:0] p);
    @(negedge clk_in);
    scale_sel = s; ref_sel = r; post_sel = p; rst_n = 1'b0;
    repeat (3) @(negedge clk_in);
    rst_n = 1'b1;
  endtask

  // waits for a rising transition seen at falling edges, then counts runs
  task automatic measure(input int ch, output int hi, output int lo);
    logic prev, cur;
    hi = 0; lo = 0;
    @(negedge clk_in); prev = pick(ch);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in); cur = pick(ch);
      if (!prev && cur) break;
      prev = cur;
    end
    hi = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in);
      if (pick(ch)) hi++; else break;
    end
    lo = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in);
      if (!pick(ch)) lo++; else break;
    end
  endtask

  task automatic follow_clock(input int ch, output int bad);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #2;
      if (pick(ch) !== 1'b1) bad++;
      @(negedge clk_in); #2;
      if (pick(ch) !== 1'b0) bad++;
    end
  endtask

  task automatic t_reset_state();
    int h, l;
    @(negedge clk_in);
    rst_n = 1'b0; scale_sel = 3'b000; ref_sel = 2'b00; post_sel = 2'b00;
    repeat (3) @(negedge clk_in);
    chk("R9 scale low in reset", int'(scale_clk), 0);
    chk("R9 ref low in reset", int'(ref_clk), 0);
    chk("R9 post low in reset", int'(post_clk), 0);
    rst_n = 1'b1;
    @(negedge clk_in);
    chk("R9 scale high after release", int'(scale_clk), 1);
    chk("R9 ref high after release", int'(ref_clk), 1);
    measure(0, h, l);
    chk("R9 first periods ratio 4", h + l, 4);
  endtask

  task automatic t_scale_codes();
    int h, l, r;
    int ratios[7] = '{4, 6, 8, 10, 12, 2, 16};
    for (int c = 0; c < 7; c++) begin
      r = ratios[c];
      do_reset(3'(c), 2'b00, 2'b00);
      measure(0, h, l);
      if (c == 5 || c == 6) begin
        chk($sformatf("R2 scale code %0d high", c), h, hi_of(r));
        chk($sformatf("R2 scale code %0d low", c), l, r - hi_of(r));
      end else begin
        chk($sformatf("R1 scale code %0d high", c), h, hi_of(r));
        chk($sformatf("R1 scale code %0d low", c), l, r - hi_of(r));
      end
    end
  endtask

  task automatic t_scale_bypass();
    int bad;
    do_reset(3'b111, 2'b00, 2'b00);
    follow_clock(0, bad);
    chk("R3 scale pass-through mismatches", bad, 0);
  endtask

  task automatic t_post_codes();
    int h, l, r;
    for (int c = 0; c < 4; c++) begin
      r = 2 << c;
      do_reset(3'b000, 2'b00, 2'(c));
      measure(2, h, l);
      chk($sformatf("R4 post code %0d high", c), h, r / 2);
      chk($sformatf("R4 post code %0d low", c), l, r / 2);
    end
  endtask

  task automatic t_ref_codes();
    int h, l, bad;
    int ratios[3] = '{2, 3, 4};
    for (int c = 0; c < 3; c++) begin
      do_reset(3'b000, 2'(c), 2'b00);
      measure(1, h, l);
      chk($sformatf("R5 ref code %0d high", c), h, hi_of(ratios[c]));
      chk($sformatf("R5 ref code %0d low", c), l, ratios[c] - hi_of(ratios[c]));
    end
    do_reset(3'b000, 2'b11, 2'b00);
    follow_clock(1, bad);
    chk("R6 ref pass-through mismatches", bad, 0);
  endtask

  task automatic t_enable();
    int bad, h, l;
    do_reset(3'b101, 2'b11, 2'b00);
    @(negedge clk_in);
    scale_en = 1'b0; ref_en = 1'b0;
    @(negedge clk_in);
    chk("R7 scale_drv low", int'(scale_drv), 0);
    chk("R7 ref_drv low", int'(ref_drv), 0);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_in); #2;
      if (scale_clk !== 1'b0 || ref_clk !== 1'b0) bad++;
      @(negedge clk_in);
      if (scale_clk !== 1'b0 || ref_clk !== 1'b0) bad++;
    end
    chk("R7 disabled outputs nonzero samples", bad, 0);
    chk("R7 post_drv stays high", int'(post_drv), 1);
    scale_en = 1'b1; ref_en = 1'b1;
    @(negedge clk_in);
    chk("R7 scale_drv restored", int'(scale_drv), 1);
    measure(0, h, l);
    chk("R7 scale resumes period", h + l, 2);
  endtask

  task automatic t_change_at_wrap();
    logic prev, cur;
    int h, l;
    do_reset(3'b110, 2'b00, 2'b00);
    @(negedge clk_in); prev = scale_clk;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in); cur = scale_clk;
      if (!prev && cur) break;
      prev = cur;
    end
    h = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in);
      if (h == 3) scale_sel = 3'b000;
      if (scale_clk) h++; else break;
    end
    l = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in);
      if (!scale_clk) l++; else break;
    end
    chk("R8 old period high kept", h, 8);
    chk("R8 old period low kept", l, 8);
    h = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_in);
      if (scale_clk) h++; else break;
    end
    chk("R8 new ratio high", h, 2);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_scale_codes();
    t_scale_bypass();
    t_post_codes();
    t_ref_codes();
    t_enable();
    t_change_at_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule